// File: doc/BRIEF.md
# Reconfigurable Lookup-Table Pipeline Stripe

This block is one stage of a pipelined reconfigurable datapath. A stripe holds N processing elements, each B bits wide. Every element has a bit-sliced lookup-table ALU and a file of P pass registers. Each operand of an element is picked by a full crossbar. The crossbar can select any pass register of the previous stripe, any pass register of this stripe, the global input bus, or zero. The second operand then goes through a funnel shifter. The vacated low bits of that operand are filled from the neighbouring lower element, so multi-element words can be shifted as one.

The ALU evaluates two 3-input tables per bit: a result table and a carry table. The carry ripples up through the bits, and it may continue into the next element so that several elements form one wider adder. Each cycle, every pass register copies the matching register of the previous stripe. The one exception is the register that the ALU is configured to write. This gives registered forwarding from stage to stage.

A single configuration word sets the behaviour of the whole stripe. The word is captured into a register and applied as one unit. A selected pass register is driven onto the global output bus. Loading the configuration and sequencing several stripes are done outside this block.

Top module: `lut_stripe`

## Requirements
- R1: A synchronous active-high `rst` clears every pass register and the active configuration to zero, so `pass_out` and `gbus_out` read zero after a reset edge.
- R2: When `cfg_load` is high at a rising edge, `cfg_in` becomes the active configuration. The computation in the next cycle uses it, and its results appear after the following edge. While `cfg_load` is low, the active configuration holds.
- R3: At each edge, pass register r of element i takes `prev_pass[(i*P+r)*B +: B]`, unless the ALU of element i targets r. `pass_out` uses the same packing.
- R4: When an element's write-enable (element bit 39) is set, its pass register numbered by the write index (element bits 42:40) takes that element's ALU result at the edge.
- R5: Each operand has a source kind, an element index and a register index. The kinds are: 0 = previous stripe register, 1 = this stripe's current register, 2 = `gbus_in`, 3 = zero. Operand A uses element bits 1:0, 5:2 and 8:6. Operand B uses bits 10:9, 14:11 and 17:15.
- R6: The shifted operand B of element i is the upper B bits of {B_i, B_(i-1)} shifted left by the shift amount (element bits 20:18). Element 0 fills with zeros, and a shift of 0 leaves B unchanged.
- R7: For each result bit k, the result is the result table (element bits 28:21) indexed by {a_k, b_k, c_k}, with a in the most significant position. The carry into bit k+1 is the carry table (bits 36:29) at the same index.
- R8: The carry into bit 0 of element i is the carry-out of element i-1 when the chain bit (bit 37) is set and i > 0. Otherwise it is the constant carry bit (bit 38).
- R9: `gbus_out` shows the current pass register named by the active configuration's output element field (bits N*43 +: 4) and output register field (the 3 bits above it).
- R10: Element i's 43-bit field occupies `cfg_in[i*43 +: 43]`. With all fields set at random and configurations reloaded at random times, the stripe's outputs follow R3 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture `cfg_in` as the active configuration |
| cfg_in | input | N*43+7 (695) | Stripe configuration word |
| prev_pass | input | N*P*B (1024) | Registered pass registers of the previous stripe |
| gbus_in | input | B | Global input bus |
| pass_out | output | N*P*B (1024) | This stripe's pass registers |
| gbus_out | output | B | Selected pass register driven to the global output bus |

## Verification
The bench attacks the configuration-timing edge: it loads a new word every other cycle. A design that applied `cfg_in` in the same cycle, or only two cycles later, would write the wrong registers. The 128-bit chained addition, including an all-ones plus one wrap, exposes a carry that fails to cross elements or is taken from the wrong neighbour. Shifts of 1 to 7 with random neighbour data expose a shifter that rotates or zero-fills instead of funnelling. Random table contents expose a swapped index order in the lookup. Reading this stripe's own registers as operands catches a design that confuses the current-stripe and previous-stripe sources.

// File: rtl/lut_stripe_pkg.sv
package lut_stripe_pkg;

    // Default parameter point: 16 elements of 8 bits, 8 pass registers each.
    localparam int DEF_ELEMS = 16;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_PASS  = 8;

    // Operand source kinds selected by the crossbar.
    typedef enum logic [1:0] {
        SRC_PREV = 2'd0,
        SRC_CUR  = 2'd1,
        SRC_GBUS = 2'd2,
        SRC_ZERO = 2'd3
    } src_kind_e;

    // Three-input table lookup, index {a, b, c} with a as the MSB.
    function automatic logic lut3(input logic [7:0] tbl,
                                  input logic a,
                                  input logic b,
                                  input logic c);
        return tbl[{a, b, c}];
    endfunction

endpackage

// File: rtl/stripe_xbar.sv
module stripe_xbar
    import lut_stripe_pkg::*;
#(
    parameter  int N  = DEF_ELEMS,
    parameter  int B  = DEF_WIDTH,
    parameter  int P  = DEF_PASS,
    localparam int EI = $clog2(N),
    localparam int RI = $clog2(P)
) (
    input  logic [N-1:0][1:0]           kind,
    input  logic [N-1:0][EI-1:0]        esel,
    input  logic [N-1:0][RI-1:0]        rsel,
    input  logic [N-1:0][P-1:0][B-1:0]  prev_regs,
    input  logic [N-1:0][P-1:0][B-1:0]  cur_regs,
    input  logic [B-1:0]                gbus,
    output logic [N-1:0][B-1:0]         opnd
);

    for (genvar i = 0; i < N; i++) begin : g_port
        logic [B-1:0] pick;
        always_comb begin
            case (src_kind_e'(kind[i]))
                SRC_PREV: pick = prev_regs[esel[i]][rsel[i]];
                SRC_CUR:  pick = cur_regs[esel[i]][rsel[i]];
                SRC_GBUS: pick = gbus;
                default:  pick = '0;
            endcase
        end
        assign opnd[i] = pick;
    end

endmodule

// File: rtl/stripe_funnel.sv
module stripe_funnel #(
    parameter  int N  = 16,
    parameter  int B  = 8,
    localparam int SI = $clog2(B)
) (
    input  logic [N-1:0][B-1:0]  din,
    input  logic [N-1:0][SI-1:0] shamt,
    output logic [N-1:0][B-1:0]  dout
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [B-1:0]   low_fill;
        logic [2*B-1:0] joined;
        if (i == 0) begin : g_edge
            assign low_fill = '0;
        end else begin : g_mid
            assign low_fill = din[i-1];
        end
        assign joined  = {din[i], low_fill} << shamt[i];
        assign dout[i] = joined[2*B-1:B];
    end

endmodule

// File: rtl/lut_alu_elem.sv
module lut_alu_elem
    import lut_stripe_pkg::*;
#(
    parameter int B = DEF_WIDTH
) (
    input  logic [B-1:0] opa,
    input  logic [B-1:0] opb,
    input  logic         cin,
    input  logic [7:0]   sum_tbl,
    input  logic [7:0]   cry_tbl,
    output logic [B-1:0] res,
    output logic         cout
);

    logic ripple;

    // Bit-serial evaluation: each slice reads the carry left by the one below.
    always_comb begin
        ripple = cin;
        res    = '0;
        for (int k = 0; k < B; k++) begin
            res[k] = lut3(sum_tbl, opa[k], opb[k], ripple);
            ripple = lut3(cry_tbl, opa[k], opb[k], ripple);
        end
        cout = ripple;
    end

endmodule

// File: rtl/lut_stripe.sv
module lut_stripe
    import lut_stripe_pkg::*;
#(
    parameter  int N     = DEF_ELEMS,
    parameter  int B     = DEF_WIDTH,
    parameter  int P     = DEF_PASS,
    localparam int EI    = $clog2(N),
    localparam int RI    = $clog2(P),
    localparam int SI    = $clog2(B),
    localparam int EW    = 2 * (2 + EI + RI) + SI + 16 + 3 + RI,
    localparam int CFG_W = N * EW + EI + RI,
    localparam int REG_W = N * P * B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [REG_W-1:0] prev_pass,
    input  logic [B-1:0]     gbus_in,
    output logic [REG_W-1:0] pass_out,
    output logic [B-1:0]     gbus_out
);

    // Per-element control field; the last member sits at the LSB.
    typedef struct packed {
        logic [RI-1:0] wr_idx;
        logic          wr_en;
        logic          cin_val;
        logic          cin_chain;
        logic [7:0]    cry_lut;
        logic [7:0]    sum_lut;
        logic [SI-1:0] shamt;
        logic [RI-1:0] b_reg;
        logic [EI-1:0] b_elem;
        src_kind_e     b_kind;
        logic [RI-1:0] a_reg;
        logic [EI-1:0] a_elem;
        src_kind_e     a_kind;
    } elem_cfg_t;

    typedef struct packed {
        logic [RI-1:0]          gout_reg;
        logic [EI-1:0]          gout_elem;
        elem_cfg_t [N-1:0]      elems;
    } stripe_cfg_t;

    stripe_cfg_t                   cfg_q;
    logic [N-1:0][P-1:0][B-1:0]    pass_q;
    logic [N-1:0][P-1:0][B-1:0]    prev_v;

    logic [N-1:0][1:0]             a_kind, b_kind;
    logic [N-1:0][EI-1:0]          a_elem, b_elem;
    logic [N-1:0][RI-1:0]          a_reg, b_reg;
    logic [N-1:0][SI-1:0]          shamt;
    logic [N-1:0][B-1:0]           opa, opb_raw, opb_sh, alu_res;

    assign prev_v   = prev_pass;
    assign pass_out = pass_q;
    assign gbus_out = pass_q[cfg_q.gout_elem][cfg_q.gout_reg];

    for (genvar i = 0; i < N; i++) begin : g_fields
        assign a_kind[i] = cfg_q.elems[i].a_kind;
        assign a_elem[i] = cfg_q.elems[i].a_elem;
        assign a_reg[i]  = cfg_q.elems[i].a_reg;
        assign b_kind[i] = cfg_q.elems[i].b_kind;
        assign b_elem[i] = cfg_q.elems[i].b_elem;
        assign b_reg[i]  = cfg_q.elems[i].b_reg;
        assign shamt[i]  = cfg_q.elems[i].shamt;
    end

    stripe_xbar #(.N(N), .B(B), .P(P)) u_xbar_a (
        .kind      (a_kind),
        .esel      (a_elem),
        .rsel      (a_reg),
        .prev_regs (prev_v),
        .cur_regs  (pass_q),
        .gbus      (gbus_in),
        .opnd      (opa)
    );

    stripe_xbar #(.N(N), .B(B), .P(P)) u_xbar_b (
        .kind      (b_kind),
        .esel      (b_elem),
        .rsel      (b_reg),
        .prev_regs (prev_v),
        .cur_regs  (pass_q),
        .gbus      (gbus_in),
        .opnd      (opb_raw)
    );

    stripe_funnel #(.N(N), .B(B)) u_funnel (
        .din   (opb_raw),
        .shamt (shamt),
        .dout  (opb_sh)
    );

    for (genvar i = 0; i < N; i++) begin : g_el
        logic         ci;
        logic         co;
        logic [B-1:0] res;
        if (i == 0) begin : g_head
            assign ci = cfg_q.elems[0].cin_val;
        end else begin : g_link
            assign ci = cfg_q.elems[i].cin_chain ? g_el[i-1].co
                                                 : cfg_q.elems[i].cin_val;
        end
        lut_alu_elem #(.B(B)) u_alu (
            .opa     (opa[i]),
            .opb     (opb_sh[i]),
            .cin     (ci),
            .sum_tbl (cfg_q.elems[i].sum_lut),
            .cry_tbl (cfg_q.elems[i].cry_lut),
            .res     (res),
            .cout    (co)
        );
        assign alu_res[i] = res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            pass_q <= '0;
        end else begin
            if (cfg_load) begin
                cfg_q <= stripe_cfg_t'(cfg_in);
            end
            for (int i = 0; i < N; i++) begin
                for (int r = 0; r < P; r++) begin
                    if (cfg_q.elems[i].wr_en && cfg_q.elems[i].wr_idx == RI'(r)) begin
                        pass_q[i][r] <= alu_res[i];
                    end else begin
                        pass_q[i][r] <= prev_v[i][r];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lut_stripe_chk.sv
module lut_stripe_chk #(
    parameter  int N     = 16,
    parameter  int B     = 8,
    parameter  int P     = 8,
    localparam int EI    = $clog2(N),
    localparam int RI    = $clog2(P),
    localparam int SI    = $clog2(B),
    localparam int EW    = 2 * (2 + EI + RI) + SI + 16 + 3 + RI,
    localparam int CFG_W = N * EW + EI + RI,
    localparam int REG_W = N * P * B
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [CFG_W-1:0] cfg_in,
    input logic [CFG_W-1:0] cfg_q,
    input logic [REG_W-1:0] prev_pass,
    input logic [REG_W-1:0] pass_out
);

    // R1: a reset edge leaves all state cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (pass_out == '0 && cfg_q == '0));

    // R2: a load captures the presented word.
    a_r2_cfg_capture: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> cfg_q == $past(cfg_in));

    // R2: without a load the active word holds.
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

    // R3: registers the ALU did not target copy the previous stripe.
    for (genvar i = 0; i < N; i++) begin : g_e
        for (genvar r = 0; r < P; r++) begin : g_r
            localparam int BASE = i * EW;
            localparam int CELL = (i * P + r) * B;
            a_r3_forward: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) &&
                 !($past(cfg_q[BASE + EW - RI - 1]) &&
                   $past(cfg_q[BASE + EW - RI +: RI]) == RI'(r)))
                |-> pass_out[CELL +: B] == $past(prev_pass[CELL +: B]));
        end
    end

endmodule

bind lut_stripe lut_stripe_chk #(.N(N), .B(B), .P(P)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_in    (cfg_in),
    .cfg_q     (cfg_q),
    .prev_pass (prev_pass),
    .pass_out  (pass_out)
);

// File: tb/tb_lut_stripe.sv
module tb_lut_stripe;

    localparam int N          = 16;
    localparam int B          = 8;
    localparam int P          = 8;
    localparam int EI         = 4;
    localparam int RI         = 3;
    localparam int EW         = 43;
    localparam int CFG_W      = N * EW + EI + RI;
    localparam int REG_W      = N * P * B;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_load = 1'b0;
    logic [CFG_W-1:0] cfg_in = '0;
    logic [REG_W-1:0] prev_pass = '0;
    logic [B-1:0]     gbus_in = '0;
    logic [REG_W-1:0] pass_out;
    logic [B-1:0]     gbus_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lut_stripe dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_in    (cfg_in),
        .prev_pass (prev_pass),
        .gbus_in   (gbus_in),
        .pass_out  (pass_out),
        .gbus_out  (gbus_out)
    );

    typedef struct {
        int ak, ae, ar, bk, be, br, sh, sl, cl, ch, cv, we, wi;
    } ecfg_t;

    ecfg_t        pend [N];
    ecfg_t        act  [N];
    int           pge, pgr, age, agr;
    logic [B-1:0] mp [N][P];
    logic [B-1:0] pv [N][P];
    logic [B-1:0] gi;
    int           nchk = 0;
    int           nbad = 0;
    bit           done = 0;
    int           add_cin = 0;

    function automatic logic [CFG_W-1:0] pack_cfg();
        logic [CFG_W-1:0] v;
        int b;
        v = '0;
        for (int i = 0; i < N; i++) begin
            b = i * EW;
            v[b      +: 2]  = 2'(pend[i].ak);
            v[b + 2  +: EI] = EI'(pend[i].ae);
            v[b + 6  +: RI] = RI'(pend[i].ar);
            v[b + 9  +: 2]  = 2'(pend[i].bk);
            v[b + 11 +: EI] = EI'(pend[i].be);
            v[b + 15 +: RI] = RI'(pend[i].br);
            v[b + 18 +: 3]  = 3'(pend[i].sh);
            v[b + 21 +: 8]  = 8'(pend[i].sl);
            v[b + 29 +: 8]  = 8'(pend[i].cl);
            v[b + 37]       = pend[i].ch[0];
            v[b + 38]       = pend[i].cv[0];
            v[b + 39]       = pend[i].we[0];
            v[b + 40 +: RI] = RI'(pend[i].wi);
        end
        v[N * EW +: EI]      = EI'(pge);
        v[N * EW + EI +: RI] = RI'(pgr);
        return v;
    endfunction

    function automatic logic [B-1:0] fetch(int k, int e, int r);
        case (k)
            0:       return pv[e][r];
            1:       return mp[e][r];
            2:       return gi;
            default: return '0;
        endcase
    endfunction

    // Behavioural next-state model; act holds the configuration used now.
    task automatic model_step(input bit load);
        logic [B-1:0] res [N];
        logic [B-1:0] rawb [N];
        logic [B-1:0] a, bs, lo;
        int c, idx;
        c = 0;
        for (int i = 0; i < N; i++) rawb[i] = fetch(act[i].bk, act[i].be, act[i].br);
        for (int i = 0; i < N; i++) begin
            a  = fetch(act[i].ak, act[i].ae, act[i].ar);
            lo = (i > 0) ? rawb[i-1] : '0;
            if (act[i].sh == 0) bs = rawb[i];
            else bs = B'((rawb[i] << act[i].sh) | (lo >> (B - act[i].sh)));
            if (!(act[i].ch != 0 && i > 0)) c = act[i].cv;
            for (int k = 0; k < B; k++) begin
                idx       = (int'(a[k]) << 2) | (int'(bs[k]) << 1) | c;
                res[i][k] = act[i].sl[idx];
                c         = (act[i].cl >> idx) & 1;
            end
        end
        for (int i = 0; i < N; i++)
            for (int r = 0; r < P; r++)
                mp[i][r] = (act[i].we != 0 && act[i].wi == r) ? res[i] : pv[i][r];
        if (load) begin
            for (int i = 0; i < N; i++) act[i] = pend[i];
            age = pge;
            agr = pgr;
        end
    endtask

    task automatic rand_inputs();
        for (int i = 0; i < N; i++)
            for (int r = 0; r < P; r++) pv[i][r] = B'($urandom);
        gi = B'($urandom);
    endtask

    task automatic gen_cfg(input int mode);
        pge = 0;
        pgr = 0;
        for (int i = 0; i < N; i++) begin
            pend[i] = '{default: 0};
            case (mode)
                1: begin
                    pend[i].ak = $urandom % 4; pend[i].ae = $urandom % N; pend[i].ar = $urandom % P;
                    pend[i].bk = $urandom % 4; pend[i].be = $urandom % N; pend[i].br = $urandom % P;
                    pend[i].sl = ($urandom % 2) ? 'hF0 : 'hCC;
                    pend[i].we = 1; pend[i].wi = $urandom % P;
                end
                2: begin
                    pend[i].ak = 3;
                    pend[i].bk = $urandom % 4; pend[i].be = $urandom % N; pend[i].br = $urandom % P;
                    pend[i].sh = $urandom % 8; pend[i].sl = 'hCC;
                    pend[i].we = 1; pend[i].wi = $urandom % P;
                end
                3: begin
                    pend[i].ak = $urandom % 4; pend[i].ae = $urandom % N; pend[i].ar = $urandom % P;
                    pend[i].bk = $urandom % 4; pend[i].be = $urandom % N; pend[i].br = $urandom % P;
                    pend[i].sl = $urandom % 256; pend[i].cl = $urandom % 256;
                    pend[i].cv = $urandom % 2;
                    pend[i].we = 1; pend[i].wi = $urandom % P;
                end
                4: begin
                    pend[i].ak = 0; pend[i].ae = i; pend[i].ar = 0;
                    pend[i].bk = 0; pend[i].be = i; pend[i].br = 1;
                    pend[i].sl = 'h96; pend[i].cl = 'hE8; pend[i].ch = 1;
                    pend[i].cv = (i == 0) ? add_cin : 0;
                    pend[i].we = 1; pend[i].wi = 2;
                end
                5: begin
                    pend[i].ak = $urandom % 4; pend[i].ae = $urandom % N; pend[i].ar = $urandom % P;
                    pend[i].bk = $urandom % 4; pend[i].be = $urandom % N; pend[i].br = $urandom % P;
                    pend[i].sh = $urandom % 8; pend[i].sl = $urandom % 256; pend[i].cl = $urandom % 256;
                    pend[i].ch = $urandom % 2; pend[i].cv = $urandom % 2;
                    pend[i].we = $urandom % 2; pend[i].wi = $urandom % P;
                end
                default: ;
            endcase
        end
        if (mode == 5) begin
            pge = $urandom % N;
            pgr = $urandom % P;
        end
    endtask

    task automatic drive(input bit load);
        for (int i = 0; i < N; i++)
            for (int r = 0; r < P; r++) prev_pass[(i * P + r) * B +: B] = pv[i][r];
        gbus_in  = gi;
        cfg_in   = pack_cfg();
        cfg_load = load;
    endtask

    task automatic compare(input string tag);
        logic [B-1:0] got;
        for (int i = 0; i < N; i++) begin
            for (int r = 0; r < P; r++) begin
                got = pass_out[(i * P + r) * B +: B];
                nchk++;
                if (got !== mp[i][r]) begin
                    nbad++;
                    $display("FAIL %s elem %0d reg %0d: actual %h expected %h",
                             tag, i, r, got, mp[i][r]);
                end
            end
        end
        nchk++;
        if (gbus_out !== mp[age][agr]) begin
            nbad++;
            $display("FAIL %s R9 gbus_out: actual %h expected %h", tag, gbus_out, mp[age][agr]);
        end
    endtask

    // One clock: inputs applied after a falling edge, outputs read at the next one.
    task automatic cycle(input bit load, input string tag);
        drive(load);
        model_step(load);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic reset_cycle();
        rst = 1'b1;
        cfg_load = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            act[i] = '{default: 0};
            for (int r = 0; r < P; r++) mp[i][r] = '0;
        end
        age = 0;
        agr = 0;
        nchk++;
        if (pass_out !== '0 || gbus_out !== '0) begin
            nbad++;
            $display("FAIL R1 reset: actual pass_out nonzero=%0b gbus_out %h expected all zero",
                     (pass_out != '0), gbus_out);
        end
        rst = 1'b0;
    endtask

    task automatic adder_run(input int cin_v, input bit saturate);
        logic [N*B-1:0] x, y, sum, got;
        add_cin = cin_v;
        gen_cfg(4);
        rand_inputs();
        cycle(1'b1, "R8");
        for (int j = 0; j < 6; j++) begin
            rand_inputs();
            if (saturate && j == 0) begin
                for (int i = 0; i < N; i++) begin
                    pv[i][0] = '1;
                    pv[i][1] = (i == 0) ? B'(1 - cin_v) : '0;
                end
            end
            for (int i = 0; i < N; i++) begin
                x[i * B +: B] = pv[i][0];
                y[i * B +: B] = pv[i][1];
            end
            cycle(1'b0, "R8");
            sum = x + y + (N*B)'(cin_v);
            for (int i = 0; i < N; i++) got[i * B +: B] = pass_out[(i * P + 2) * B +: B];
            nchk++;
            if (got !== sum) begin
                nbad++;
                $display("FAIL R8 chained add: actual %h expected %h", got, sum);
            end
        end
    endtask

    task automatic run_phase(input int mode, input int loads, input int gap, input string tag);
        for (int l = 0; l < loads; l++) begin
            gen_cfg(mode);
            rand_inputs();
            cycle(1'b1, tag);
            for (int g = 0; g < gap; g++) begin
                rand_inputs();
                cycle(1'b0, tag);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nbad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pend[i] = '{default: 0};
            for (int r = 0; r < P; r++) pv[i][r] = '0;
        end
        gi = '0;
        pge = 0;
        pgr = 0;
        @(negedge clk);
        @(negedge clk);
        reset_cycle();                  // R1 from power-up
        run_phase(0, 1, 8, "R3");       // no writes: pure forwarding
        run_phase(5, 12, 1, "R2");      // reload every other cycle
        run_phase(5, 6, 0, "R2");       // reload every cycle
        run_phase(1, 6, 3, "R5 R4");    // operand sources, ALU write target
        run_phase(2, 6, 3, "R6");       // funnel shift
        run_phase(3, 6, 3, "R7");       // arbitrary tables
        adder_run(0, 1'b1);             // R8 wrap through all elements
        adder_run(1, 1'b1);
        run_phase(5, 8, 2, "R9");       // random output selection
        run_phase(5, 40, 3, "R10");     // full random configuration
        reset_cycle();                  // R1 from nonzero state
        run_phase(5, 4, 2, "R10");
        finish_run();
    end

endmodule